// File: doc/BRIEF.md
# Configurable Serial Transmit Engine

This block sends asynchronous serial frames on a single line. Software sets up the frame shape and the bit rate by writing three small registers over a write-only register bus. The first control register holds the word length code, the parity controls and the oversampling mode. The second control register holds the stop bit code. The rate register holds the divisor. The block decodes these registers into a line configuration and flags any combination that it cannot send.

A client hands over one data word at a time through a valid/ready handshake. The engine takes a snapshot of the decoded configuration when it accepts a word. It then drives a low start bit, the data bits with the least significant bit first, an optional parity bit and one or two high stop bits. The line idles high. Each bit lasts the effective divisor in clock cycles.

Register writes made during a frame apply only from the next frame. While the configuration is invalid, the engine refuses new words.

Top module: `ser_tx_engine`

## Requirements
- R1: After reset the line is high, `busy` and `config_error` are low and `tx_ready` is high. The reset configuration is 8 data bits, no parity, 1 stop bit, oversampling by 16 and a rate register of 16.
- R2: A frame is one low start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits at high level. Every bit lasts exactly the effective divisor in clock cycles.
- R3: The word length code is {ctrl_a[1], ctrl_a[0]}. Code 00 sends 8 data bits, 01 sends 9 and 10 sends 7. Code 11 raises `config_error`.
- R4: ctrl_a[2] enables the parity bit. When enabled, ctrl_a[3]=1 selects odd parity and ctrl_a[3]=0 selects even parity, counted over the data bits sent.
- R5: The stop code ctrl_b[1:0] sends 1 stop bit for code 0 and 2 stop bits for code 2. Codes 1 and 3 raise `config_error`.
- R6: With ctrl_a[4]=0 (oversampling by 16), the effective divisor equals the 16-bit rate register.
- R7: With ctrl_a[4]=1 (oversampling by 8), the effective divisor is {rate[15:4], rate[2:0]}, which is the re-encoded value halved. A set rate[3] raises `config_error`.
- R8: A rate register value below 16 raises `config_error`. The value 16 itself is legal.
- R9: While `config_error` is high, `tx_ready` is low, an asserted `tx_valid` starts no frame and the line stays high.
- R10: A frame in flight keeps the settings it latched at acceptance. A register write made during the frame applies to the next frame.
- R11: Register addresses are 0 for ctrl_a, 1 for ctrl_b and 2 for the rate register. A write updates the decoded configuration and `config_error` on its own clock edge. Writes to address 3 change nothing.
- R12: `busy` rises on the clock edge that accepts a word. It falls on the edge that ends the last stop bit. `tx_ready` is low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 ctrl_a, 1 ctrl_b, 2 rate) |
| reg_wdata | input | 16 | Register write data |
| tx_data | input | 9 | Word to send; only the configured number of low bits is used |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Engine can accept a word |
| busy | output | 1 | A frame is on the line |
| config_error | output | 1 | Current configuration cannot be sent |
| tx_out | output | 1 | Serial line, idle high |

## Verification
The bit counter, the shift register and the divisor latched for a frame can each go wrong without any immediate sign. A bad bit counter shows up as a frame whose `busy` falls a whole bit period early or late, so the bench watches for the fall in the exact cycle. A wrong shift register or parity value shows up as a wrong line level in the middle of a bit, so the bench samples every bit at its midpoint. A divisor that follows the registers instead of the latched copy stretches the rest of the frame, so one frame is rewritten mid-flight to expose it. A decode fault in the configuration path shows on `config_error` and `tx_ready` on the cycle after the offending write.

// File: rtl/ser_tx_pkg.sv
// Shared constants and types for the serial transmit engine.
// Assumes at most 9 data bits and a 16-bit rate register.
package ser_tx_pkg;
    localparam int DATA_BITS = 9;
    localparam int RATE_BITS = 16;
    localparam int MIN_RATE  = 16;
    localparam int CTRLA_W   = 5;
    localparam int CTRLB_W   = 2;
    localparam int NBITS_W   = $clog2(DATA_BITS + 1);

    typedef enum logic [1:0] {
        ADDR_CTRL_A = 2'd0,
        ADDR_CTRL_B = 2'd1,
        ADDR_RATE   = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [NBITS_W-1:0]   nbits;
        logic                 par_en;
        logic                 par_odd;
        logic                 stop2;
        logic [RATE_BITS-1:0] divisor;
    } line_cfg_t;
endpackage

// File: rtl/ser_tx_cfg_regs.sv
// Holds the three configuration registers and decodes them into a line
// configuration and an invalid flag. The decode is combinational, so a
// write is reflected on the cycle after its edge.
module ser_tx_cfg_regs
    import ser_tx_pkg::*;
#(
    parameter logic [RATE_BITS-1:0] RATE_RST = RATE_BITS'(MIN_RATE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [RATE_BITS-1:0] wdata,
    output line_cfg_t            cfg,
    output logic                 cfg_bad
);
    logic [CTRLA_W-1:0]   ctrl_a;
    logic [CTRLB_W-1:0]   ctrl_b;
    logic [RATE_BITS-1:0] rate;

    // Register file: decoded writes, unknown addresses dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
            rate   <= RATE_RST;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL_A: ctrl_a <= wdata[CTRLA_W-1:0];
                ADDR_CTRL_B: ctrl_b <= wdata[CTRLB_W-1:0];
                ADDR_RATE:   rate   <= wdata;
                default:     ;
            endcase
        end
    end

    // Decode word length, parity, stop bits and divisor; collect faults.
    always_comb begin
        cfg_bad     = 1'b0;
        cfg.par_en  = ctrl_a[2];
        cfg.par_odd = ctrl_a[3];
        case (ctrl_a[1:0])
            2'b00:   cfg.nbits = NBITS_W'(8);
            2'b01:   cfg.nbits = NBITS_W'(9);
            2'b10:   cfg.nbits = NBITS_W'(7);
            default: begin
                cfg.nbits = NBITS_W'(8);
                cfg_bad   = 1'b1;
            end
        endcase
        case (ctrl_b)
            2'd0:    cfg.stop2 = 1'b0;
            2'd2:    cfg.stop2 = 1'b1;
            default: begin
                cfg.stop2 = 1'b0;
                cfg_bad   = 1'b1;
            end
        endcase
        if (rate < RATE_BITS'(MIN_RATE))
            cfg_bad = 1'b1;
        if (ctrl_a[4]) begin
            cfg.divisor = {1'b0, rate[RATE_BITS-1:4], rate[2:0]};
            if (rate[3])
                cfg_bad = 1'b1;
        end else begin
            cfg.divisor = rate;
        end
    end
endmodule

// File: rtl/ser_tx_baud.sv
// Bit-period counter. Latches the divisor when a frame is loaded and
// issues a one-cycle tick every divisor cycles while running.
// Assumes a divisor of at least 2, which the configuration check ensures.
module ser_tx_baud
    import ser_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 run,
    input  logic [RATE_BITS-1:0] divisor,
    output logic                 tick
);
    logic [RATE_BITS-1:0] div_q;
    logic [RATE_BITS-1:0] cnt;

    // Down-counter with reload from the divisor latched for this frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= divisor;
            cnt   <= divisor - 1'b1;
        end else if (run) begin
            if (cnt == '0)
                cnt <= div_q - 1'b1;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && !load && (cnt == '0);
endmodule

// File: rtl/ser_tx_shift.sv
// Frame builder and shifter. On acceptance it builds the whole frame
// (start, data LSB first, parity, stop) into a shift register and moves
// one bit per tick. The line idles high when no frame is in flight.
module ser_tx_shift
    import ser_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  line_cfg_t            cfg,
    input  logic                 cfg_bad,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 valid,
    input  logic                 tick,
    output logic                 ready,
    output logic                 accept,
    output logic                 busy,
    output logic                 tx
);
    localparam int FRAME_W = DATA_BITS + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int IDX_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   frame_len;
    logic [CNT_W-1:0]   left;
    logic [IDX_W-1:0]   par_idx;
    logic               par;

    assign ready  = !busy && !cfg_bad;
    assign accept = valid && ready;
    assign tx     = busy ? sr[0] : 1'b1;

    // Assemble the frame image and its length from the live configuration.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        par      = cfg.par_odd;
        for (int i = 0; i < DATA_BITS; i++) begin
            if (i < int'(cfg.nbits)) begin
                frame[i+1] = data[i];
                par        = par ^ data[i];
            end
        end
        par_idx = IDX_W'(cfg.nbits) + 1'b1;
        if (cfg.par_en)
            frame[par_idx] = par;
        frame_len = CNT_W'(cfg.nbits) + CNT_W'(cfg.par_en)
                  + (cfg.stop2 ? CNT_W'(3) : CNT_W'(2));
    end

    // Load on acceptance, shift one bit per tick, leave after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '1;
            left <= '0;
            busy <= 1'b0;
        end else if (accept) begin
            sr   <= frame;
            left <= frame_len;
            busy <= 1'b1;
        end else if (busy && tick) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - 1'b1;
            if (left == CNT_W'(1))
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/ser_tx_engine.sv
// Top of the serial transmit engine: configuration registers, bit-period
// counter and frame shifter. Assumes one word in flight at a time.
module ser_tx_engine
    import ser_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [RATE_BITS-1:0] reg_wdata,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic                 busy,
    output logic                 config_error,
    output logic                 tx_out
);
    line_cfg_t cfg;
    logic      accept;
    logic      tick;

    ser_tx_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .cfg     (cfg),
        .cfg_bad (config_error)
    );

    ser_tx_baud u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .run     (busy),
        .divisor (cfg.divisor),
        .tick    (tick)
    );

    ser_tx_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .cfg_bad (config_error),
        .data    (tx_data),
        .valid   (tx_valid),
        .tick    (tick),
        .ready   (tx_ready),
        .accept  (accept),
        .busy    (busy),
        .tx      (tx_out)
    );
endmodule

// File: rtl/ser_tx_checker.sv
// Port-level protocol checks for the serial transmit engine, bound to the top.
module ser_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic busy,
    input logic config_error,
    input logic tx_out
);
    // R2: a frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_out);
    // R2: the last bit before the frame ends is a high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_out));
    // R9: an invalid configuration withholds ready
    p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> !tx_ready);
    // R9: no frame starts from an idle engine with a bad configuration
    p_err_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && config_error) |=> !busy);
    // R12: no new word is taken during a frame
    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_ready);
    // R12: an accepted word starts a frame on the next cycle
    p_accept_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (busy && !tx_out));
endmodule

bind ser_tx_engine ser_tx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .busy         (busy),
    .config_error (config_error),
    .tx_out       (tx_out)
);

// File: tb/ser_tx_engine_tb.sv
`timescale 1ns/1ps
module ser_tx_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [8:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, busy, config_error, tx_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ser_tx_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .busy(busy), .config_error(config_error),
        .tx_out(tx_out)
    );

    // Vector table: ctrl_a, ctrl_b, rate, data and the expected line shape.
    localparam logic [4:0]  V_A[6]    = '{5'h00, 5'h05, 5'h0E, 5'h10, 5'h1C, 5'h0D};
    localparam logic [1:0]  V_B[6]    = '{2'd0, 2'd2, 2'd0, 2'd0, 2'd2, 2'd0};
    localparam logic [15:0] V_RATE[6] = '{16'd16, 16'd20, 16'd17, 16'h0023, 16'h0027, 16'd18};
    localparam logic [8:0]  V_DATA[6] = '{9'h0A5, 9'h1B3, 9'h055, 9'h03C, 9'h0FF, 9'h100};
    localparam int          V_DIV[6]  = '{16, 20, 17, 19, 23, 18};
    localparam int          V_NB[6]   = '{8, 9, 7, 8, 8, 9};
    localparam bit          V_PE[6]   = '{0, 1, 1, 0, 1, 1};
    localparam bit          V_PO[6]   = '{0, 0, 1, 0, 1, 1};
    localparam bit          V_S2[6]   = '{0, 1, 0, 0, 1, 0};

    function automatic string vtag(input int v);
        case (v)
            0: return "R2 R6";
            1: return "R3 R4 R5";
            2: return "R3 R4";
            3: return "R7";
            4: return "R4 R5 R7";
            default: return "R3 R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Send one word and check every bit at its midpoint plus the busy edge.
    task automatic send(input logic [8:0] d, input int dv, input int nb, input bit pe,
                        input bit po, input bit st2, input bit mid, input string req);
        int total;
        int m;
        bit p;
        bit e;
        total = 1 + nb + int'(pe) + (st2 ? 2 : 1);
        p = po;
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        @(negedge clk);
        chk(tx_ready === 1'b1, {req, " ready"}, int'(tx_ready), 1);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        m = 0;
        if (mid) begin
            reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'd32;
            @(negedge clk);
            reg_wr = 1'b0;
            m = 1;
        end
        for (int b = 0; b < total; b++) begin
            int tgt;
            tgt = b * dv + dv / 2;
            repeat (tgt - m) @(negedge clk);
            m = tgt;
            if (b == 0) e = 1'b0;
            else if (b <= nb) e = d[b-1];
            else if (pe && b == nb + 1) e = p;
            else e = 1'b1;
            chk(tx_out === e, {req, " line bit"}, int'(tx_out), int'(e));
        end
        repeat (total * dv - 1 - m) @(negedge clk);
        chk(busy === 1'b1, {req, " R12 busy before end"}, int'(busy), 1);
        @(negedge clk);
        chk(busy === 1'b0, {req, " R12 busy after end"}, int'(busy), 0);
        chk(tx_out === 1'b1, {req, " idle line"}, int'(tx_out), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tx_out === 1'b1, "R1 line", int'(tx_out), 1);
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(config_error === 1'b0, "R1 error", int'(config_error), 0);
        chk(tx_ready === 1'b1, "R1 ready", int'(tx_ready), 1);
        send(9'h0C3, 16, 8, 0, 0, 0, 0, "R1 default frame");

        // Table walk over word lengths, parity, stop codes and both rate modes.
        for (int v = 0; v < 6; v++) begin
            wr(2'd0, {11'd0, V_A[v]});
            wr(2'd1, {14'd0, V_B[v]});
            wr(2'd2, V_RATE[v]);
            chk(config_error === 1'b0, {vtag(v), " R11 config ok"}, int'(config_error), 0);
            send(V_DATA[v], V_DIV[v], V_NB[v], V_PE[v], V_PO[v], V_S2[v], 0, vtag(v));
        end

        // R8 / R9: rate below 16 is refused and blocks a start.
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000);
        wr(2'd2, 16'd15);
        chk(config_error === 1'b1, "R8 rate 15", int'(config_error), 1);
        chk(tx_ready === 1'b0, "R9 ready low", int'(tx_ready), 0);
        @(negedge clk); tx_valid = 1'b1; tx_data = 9'h000;
        repeat (20) @(negedge clk);
        chk(busy === 1'b0, "R9 no start", int'(busy), 0);
        chk(tx_out === 1'b1, "R9 line idle", int'(tx_out), 1);
        tx_valid = 1'b0;
        wr(2'd2, 16'd16);
        chk(config_error === 1'b0, "R8 rate 16 legal", int'(config_error), 0);

        // R3: word length code 11.
        wr(2'd0, 16'h0003);
        chk(config_error === 1'b1, "R3 code 11", int'(config_error), 1);
        wr(2'd0, 16'h0000);
        chk(config_error === 1'b0, "R3 code 00", int'(config_error), 0);

        // R5: fractional stop codes.
        wr(2'd1, 16'h0001);
        chk(config_error === 1'b1, "R5 code 1", int'(config_error), 1);
        wr(2'd1, 16'h0003);
        chk(config_error === 1'b1, "R5 code 3", int'(config_error), 1);
        wr(2'd1, 16'h0000);
        chk(config_error === 1'b0, "R5 code 0", int'(config_error), 0);

        // R7: reserved bit in oversampling by 8, then the smallest legal rate.
        wr(2'd0, 16'h0010);
        wr(2'd2, 16'h0028);
        chk(config_error === 1'b1, "R7 reserved bit", int'(config_error), 1);
        wr(2'd2, 16'h0010);
        chk(config_error === 1'b0, "R7 rate 0x10", int'(config_error), 0);
        send(9'h081, 8, 8, 0, 0, 0, 0, "R7 divisor 8");

        // R11: address 3 is ignored.
        wr(2'd3, 16'h0000);
        chk(config_error === 1'b0, "R11 addr 3 ignored", int'(config_error), 0);
        send(9'h042, 8, 8, 0, 0, 0, 0, "R11 after addr 3");

        // R10: rewrite the rate mid-frame; the frame keeps its divisor.
        wr(2'd0, 16'h0000); wr(2'd2, 16'd16);
        send(9'h00F, 16, 8, 0, 0, 0, 1, "R10 in flight");
        send(9'h00F, 32, 8, 0, 0, 0, 0, "R10 next frame");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule